// File: doc/BRIEF.md
# Ternary Register File with Guarded Zero Register

This block holds the general-purpose registers of a balanced-ternary processor core. It keeps 27 registers, numbered 0 to 26, each one 20 trits wide. Every trit is carried as a 2-bit code, and trit 0 is the least significant one, in bits [1:0] of a word. Two read ports are combinational. One write port commits on the rising clock edge. A read returns the value that the addressed register will hold after the coming edge, so a value written in the same cycle reaches the reader at once.

Register 0 is the constant zero. It cannot be written. A write aimed at it, or at an address that names no register, is refused and reported on a one-cycle fault pulse rather than dropped silently. Register 1 is the stack pointer. A push strobe moves it down by one 20-trit word (4 trytes), and a pop strobe moves it up by the same amount, using balanced-ternary arithmetic. Register 26 is the link register. A call loads it with the return address through its own strobe.

All pins are plain per-cycle controls and data with no valid/ready handshake. The core issues at most one update per path per cycle, and the file never stalls, so no back-pressure exists.

Top module: `trit_regfile`

## Requirements
- R1: Trit codes are 2'b00 = -1, 2'b01 = 0 and 2'b10 = +1, and trit t of a word sits at bits [2t+1:2t]. A write with wr_en high to an address from 1 to 26 stores wr_data, and both read ports then return it.
- R2: After reset, every register holds zero, which is code 2'b01 in each of its 20 trits.
- R3: Reading address 0, or any address from 27 to 31, returns the all-zero word.
- R4: A write with wr_en high to address 0 or to any address from 27 to 31 raises wr_fault in the next cycle and changes no register. wr_fault is high for exactly the cycles that follow faulting writes and is low otherwise.
- R5: A read port addressing a register that is updated in the current cycle returns the new value in that same cycle. This holds for the write port, push, pop and link.
- R6: When push is high and pop is low, R1 decreases by 4. When pop is high and push is low, R1 increases by 4. Both operations wrap modulo 3^20 within the range -1743392200..1743392200. With both strobes high, or both low, R1 is unchanged.
- R7: When link_en is high, R26 is loaded with link_data.
- R8: A legal write through the write port overrides push and pop on R1 and overrides link on R26 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_addr_a | input | 5 | Read port A address |
| rd_data_a | output | 40 | Read port A data, 20 trit codes |
| rd_addr_b | input | 5 | Read port B address |
| rd_data_b | output | 40 | Read port B data, 20 trit codes |
| wr_en | input | 1 | Write port enable |
| wr_addr | input | 5 | Write port address |
| wr_data | input | 40 | Write port data |
| push | input | 1 | Stack-pointer decrement strobe |
| pop | input | 1 | Stack-pointer increment strobe |
| link_en | input | 1 | Link-register load strobe |
| link_data | input | 40 | Return address for the link register |
| wr_fault | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench goes after the stack-pointer wrap at both ends of the 20-trit range. An adder that keeps the final carry, or that mishandles the balanced-digit correction, lands on the wrong value there. It sweeps every illegal write address and then re-reads the whole file, which catches a design that lets a refused write land in a register or that holds the fault high. It drives conflicting strobes on the same cycle: a write against push, a write against link, push against pop, and a refused write against link. It checks each read in the cycle of its write, so a missing bypass or a wrong priority among the update paths shows up as a stale or swapped value.

// File: rtl/tern_pkg.sv
package tern_pkg;
  localparam logic [1:0] TC_NEG  = 2'b00;
  localparam logic [1:0] TC_ZERO = 2'b01;
  localparam logic [1:0] TC_POS  = 2'b10;

  function automatic int trit_val(input logic [1:0] code);
    case (code)
      TC_NEG:  trit_val = -1;
      TC_POS:  trit_val = 1;
      default: trit_val = 0;
    endcase
  endfunction

  function automatic logic [1:0] trit_code(input int v);
    if (v < 0)       trit_code = TC_NEG;
    else if (v > 0)  trit_code = TC_POS;
    else             trit_code = TC_ZERO;
  endfunction
endpackage

// File: rtl/tern_step_add.sv
module tern_step_add
  import tern_pkg::*;
#(
  parameter int TRITS = 20,
  parameter int STEP  = 4
) (
  input  logic [2*TRITS-1:0] word_i,
  input  logic               sub_i,
  output logic [2*TRITS-1:0] word_o
);
  always_comb begin
    int k;
    int r;
    int c;
    int s;
    k = sub_i ? -STEP : STEP;
    c = 0;
    word_o = '0;
    for (int t = 0; t < TRITS; t++) begin
      r = k % 3;
      if (r == 2)       r = -1;
      else if (r == -2) r = 1;
      k = (k - r) / 3;
      s = trit_val(word_i[2*t +: 2]) + r + c;
      if (s > 1) begin
        s = s - 3;
        c = 1;
      end else if (s < -1) begin
        s = s + 3;
        c = -1;
      end else begin
        c = 0;
      end
      word_o[2*t +: 2] = trit_code(s);
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port #(
  parameter int NREG  = 27,
  parameter int TRITS = 20,
  parameter int AW    = 5
) (
  input  logic [AW-1:0]      addr,
  input  logic [2*TRITS-1:0] words [NREG],
  output logic [2*TRITS-1:0] data
);
  localparam logic [2*TRITS-1:0] ZERO_W = {TRITS{2'b01}};

  always_comb begin
    data = ZERO_W;
    for (int i = 1; i < NREG; i++)
      if (addr == AW'(i)) data = words[i];
  end
endmodule

// File: rtl/trit_regfile.sv
module trit_regfile
  import tern_pkg::*;
#(
  parameter int NREG   = 27,
  parameter int TRITS  = 20,
  parameter int AW     = 5,
  parameter int SP_IDX = 1,
  parameter int LR_IDX = 26,
  parameter int SP_STEP = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [AW-1:0]        rd_addr_a,
  output logic [2*TRITS-1:0]   rd_data_a,
  input  logic [AW-1:0]        rd_addr_b,
  output logic [2*TRITS-1:0]   rd_data_b,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [2*TRITS-1:0]   wr_data,
  input  logic                 push,
  input  logic                 pop,
  input  logic                 link_en,
  input  logic [2*TRITS-1:0]   link_data,
  output logic                 wr_fault
);
  localparam int W = 2*TRITS;
  localparam logic [W-1:0] ZERO_W = {TRITS{TC_ZERO}};

  logic [W-1:0] regs_q [NREG];
  logic [W-1:0] regs_d [NREG];
  logic [W-1:0] sp_moved;
  logic         bad_wr;
  logic         good_wr;
  logic         sp_move;

  assign bad_wr  = wr_en && (wr_addr == '0 || wr_addr >= AW'(NREG));
  assign good_wr = wr_en && !bad_wr;
  assign sp_move = push ^ pop;

  tern_step_add #(.TRITS(TRITS), .STEP(SP_STEP)) u_sp_add (
    .word_i (regs_q[SP_IDX]),
    .sub_i  (push),
    .word_o (sp_moved)
  );

  generate
    for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
        assign regs_d[i] = ZERO_W;
      end else begin : g_rw
        always_comb begin
          regs_d[i] = regs_q[i];
          if (i == SP_IDX && sp_move) regs_d[i] = sp_moved;
          if (i == LR_IDX && link_en) regs_d[i] = link_data;
          if (good_wr && wr_addr == AW'(i)) regs_d[i] = wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q[i] <= ZERO_W;
        else        regs_q[i] <= regs_d[i];
      end

      if (i != SP_IDX && i != LR_IDX) begin : g_keep
        AST_FAULT_KEEPS_REG: assert property (@(posedge clk) disable iff (!rst_n)
          (!wr_en || bad_wr) |=> $stable(regs_q[i])); // R4
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_fault <= 1'b0;
    else        wr_fault <= bad_wr;
  end

  rf_read_port #(.NREG(NREG), .TRITS(TRITS), .AW(AW)) u_rd_a (
    .addr (rd_addr_a), .words (regs_d), .data (rd_data_a)
  );
  rf_read_port #(.NREG(NREG), .TRITS(TRITS), .AW(AW)) u_rd_b (
    .addr (rd_addr_b), .words (regs_d), .data (rd_data_b)
  );

  AST_FAULT_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> wr_fault); // R4
  AST_FAULT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_wr |=> !wr_fault); // R4
  AST_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_a == '0) |-> (rd_data_a == ZERO_W)); // R3
  AST_LINK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && !(good_wr && wr_addr == AW'(LR_IDX))) |=> (regs_q[LR_IDX] == $past(link_data))); // R7
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sp_move && !(good_wr && wr_addr == AW'(SP_IDX))) |=> $stable(regs_q[SP_IDX])); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr |=> (regs_q[$past(wr_addr)] == $past(wr_data))); // R8
endmodule

// File: tb/sim_trit_regfile.sv
module sim_trit_regfile;
  localparam int CLK_P = 10;
  localparam longint M = 64'sd1743392200;
  localparam longint MOD = 2*M + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0]  rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
  logic [39:0] rd_data_a, rd_data_b, wr_data = '0, link_data = '0;
  logic wr_en = 0, push = 0, pop = 0, link_en = 0;
  logic wr_fault;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;
  longint model [27];

  always #(CLK_P/2) clk = ~clk;

  trit_regfile u0 (
    .clk(clk), .rst_n(rst_n),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .push(push), .pop(pop), .link_en(link_en), .link_data(link_data),
    .wr_fault(wr_fault)
  );

  function automatic logic [39:0] enc(input longint v);
    longint k = v;
    longint r;
    logic [39:0] w;
    for (int t = 0; t < 20; t++) begin
      r = k % 3;
      if (r == 2) r = -1;
      else if (r == -2) r = 1;
      k = (k - r) / 3;
      w[2*t +: 2] = (r < 0) ? 2'b00 : (r > 0) ? 2'b10 : 2'b01;
    end
    return w;
  endfunction

  function automatic longint wrapv(input longint v);
    if (v > M)  return v - MOD;
    if (v < -M) return v + MOD;
    return v;
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; push = 0; pop = 0; link_en = 0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < 32; a++) begin
      rd_addr_a = 5'(a);
      rd_addr_b = 5'(31 - a);
      #1;
      chk(req, rd_data_a, (a < 27) ? enc(model[a]) : enc(0));
      chk(req, rd_data_b, (31 - a < 27) ? enc(model[31 - a]) : enc(0));
    end
  endtask

  task automatic do_write(input int a, input longint v);
    wr_en = 1; wr_addr = 5'(a); wr_data = enc(v);
    rd_addr_a = 5'(a);
    #1;
    if (a >= 1 && a <= 26) begin
      chk("R5 write bypass", rd_data_a, enc(v));
      model[a] = v;
    end else begin
      chk("R3 refused write not visible", rd_data_a, enc(0));
    end
    step();
    idle();
    chk("R4 fault flag", {39'd0, wr_fault}, {39'd0, (a == 0 || a > 26)});
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 27; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R2 and R3: reset contents and illegal reads
    sweep("R2 reset zero");
    chk("R4 no fault after reset", {39'd0, wr_fault}, 40'd0);

    // R1: store a distinct value in every writable register
    for (int r = 1; r < 27; r++) begin
      longint v = longint'(r) * 64'sd65432101 - 64'sd900000000;
      if (r % 2 == 1) v = -v;
      do_write(r, v);
    end
    sweep("R1 readback");

    // R4: refused writes, the fault pulse and unchanged contents
    do_write(0, 5);
    chk("R3 zero reg after write", rd_data_a, enc(0));
    step();
    chk("R4 fault lasts one cycle", {39'd0, wr_fault}, 40'd0);
    for (int a = 27; a < 32; a++) do_write(a, 12345);
    step();
    chk("R4 fault clears", {39'd0, wr_fault}, 40'd0);
    sweep("R4 no change after refused writes");

    // R6: push and pop with bypass
    push = 1; rd_addr_a = 5'd1; #1;
    model[1] = wrapv(model[1] - 4);
    chk("R5 push bypass", rd_data_a, enc(model[1]));
    step(); idle(); #1;
    chk("R6 push", rd_data_a, enc(model[1]));
    pop = 1; step(); idle(); #1;
    model[1] = wrapv(model[1] + 4);
    chk("R6 pop", rd_data_a, enc(model[1]));
    push = 1; pop = 1; step(); idle(); #1;
    chk("R6 push and pop cancel", rd_data_a, enc(model[1]));
    for (int k = 0; k < 20; k++) begin
      push = (k % 3 != 0); pop = ~push;
      model[1] = wrapv(model[1] + (push ? -4 : 4));
      step(); idle(); #1;
      chk("R6 sequence", rd_data_a, enc(model[1]));
    end

    // R6: wrap at both ends of the range
    do_write(1, -M + 2);
    push = 1; step(); idle(); rd_addr_a = 5'd1; #1;
    model[1] = M - 1;
    chk("R6 wrap low", rd_data_a, enc(model[1]));
    pop = 1; step(); idle(); #1;
    model[1] = -M + 2;
    chk("R6 wrap high", rd_data_a, enc(model[1]));

    // R8: write wins over push on R1
    wr_en = 1; wr_addr = 5'd1; wr_data = enc(314159); push = 1;
    step(); idle(); #1;
    model[1] = 314159;
    chk("R8 write over push", rd_data_a, enc(model[1]));

    // R7: link load with bypass
    link_en = 1; link_data = enc(-777777); rd_addr_b = 5'd26; #1;
    chk("R5 link bypass", rd_data_b, enc(-777777));
    step(); idle(); #1;
    model[26] = -777777;
    chk("R7 link load", rd_data_b, enc(model[26]));

    // R8: write wins over link on R26
    link_en = 1; link_data = enc(11); wr_en = 1; wr_addr = 5'd26; wr_data = enc(22);
    step(); idle(); #1;
    model[26] = 22;
    chk("R8 write over link", rd_data_b, enc(model[26]));

    // R7 with R4: a refused write does not block link
    link_en = 1; link_data = enc(-5); wr_en = 1; wr_addr = 5'd0; wr_data = enc(9);
    step(); idle(); #1;
    model[26] = -5;
    chk("R7 link beside fault", rd_data_b, enc(model[26]));
    chk("R4 fault beside link", {39'd0, wr_fault}, 40'd1);
    step();
    sweep("R1 final contents");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule